// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit Mark

This block moves 36-bit words from a writer clocked by `clk_a` to a reader clocked by `clk_b`. The two clocks may be unrelated or may share edges. The output is first-word-fall-through. The oldest stored word sits in an output register and is visible on `b_data` while `out_ready` is high. A read acknowledges that word and lets the next one fall through. Write and read pointers carry one extra wrap bit and cross between the clock domains in Gray code through two flops. The write side derives `in_ready` and `almost_full_n`, and the read side derives `out_ready` and `almost_empty_n`.

A retransmit facility lets the reader mark the word currently shown at the output. Later the reader can rewind to that word and read the data again. While the mark is held, the writer may not overwrite the marked word or any word after it, so the mark point and not the read head limits writing. The read side is a four-state machine with two bits: whether a mark is held and whether the output register holds a word. The states are `RS_DRY` (no word, no mark), `RS_HOLD` (word shown, no mark), `RS_MARK_DRY` (mark held, no word) and `RS_MARK_HOLD` (mark held, word shown). Its transitions are named as follows:
- **fetch**: `*_DRY` to `*_HOLD`, when a word arrives.
- **drain**: `*_HOLD` to `*_DRY`, when the last word is read.
- **mark**: `RS_HOLD` to `RS_MARK_HOLD`, when `retx_mode` is high.
- **release**: any `RS_MARK_*` to the unmarked state with the same word status, when `retx_mode` is low.
- **rewind**: any `RS_MARK_*` to `RS_MARK_HOLD`, when `rewind` is high.

Top module: `mark_fifo`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_ready` are low, `almost_empty_n` is low and `almost_full_n` is high. `in_ready` goes high on the first `clk_a` rising edge after `rst_n` is released.
- R2: A write happens on a `clk_a` rising edge only when `a_cs_n`=0, `a_en`=1, `a_wr`=1 and `in_ready`=1. If any one of these qualifiers is missing, nothing is stored.
- R3: Words leave in the order they were written. The oldest word is on `b_data` whenever `out_ready` is high. A read happens on a `clk_b` edge only when `b_cs_n`=0, `b_en`=1 and `b_rd`=1. The read exposes the next word, or drops `out_ready` if none is left.
- R4: After a word is written into an empty FIFO, `out_ready` rises on the third `clk_b` rising edge following the write edge.
- R5: `in_ready` goes low once DEPTH words are stored, and the word held in the output register counts as stored. Writes attempted while `in_ready` is low are not stored.
- R6: A read attempted while `out_ready` is low has no effect. A word written later is still delivered.
- R7: `almost_empty_n` is low when the stored word count is at most AE_LEVEL, and high otherwise.
- R8: `almost_full_n` is low when the number of free locations is at most AF_LEVEL, and high otherwise.
- R9: A `clk_b` edge with `retx_mode` high and `out_ready` high marks the word on `b_data` and enters retransmit mode. Without `out_ready`, no mark is taken.
- R10: In retransmit mode, a `clk_b` edge with `rewind` high puts the marked word back on `b_data` with `out_ready` high. Following reads then continue in order from that word.
- R11: In retransmit mode, `in_ready` goes low once the write pointer is DEPTH words ahead of the mark, so marked data is never overwritten.
- R12: A `clk_b` edge with `retx_mode` low leaves retransmit mode. After that, `rewind` has no effect, and the write limit follows the read head again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs_n | input | 1 | Write port select, active low |
| a_en | input | 1 | Write port enable |
| a_wr | input | 1 | High selects a write on port A |
| a_data | input | DW (36) | Write data |
| b_cs_n | input | 1 | Read port select, active low |
| b_en | input | 1 | Read port enable |
| b_rd | input | 1 | High selects a read on port B |
| retx_mode | input | 1 | Take and hold a retransmit mark |
| rewind | input | 1 | Reload the marked word while in retransmit mode |
| b_data | output | DW (36) | Output register, oldest word |
| in_ready | output | 1 | Space available for a write |
| almost_full_n | output | 1 | Low when free locations are at most AF_LEVEL |
| out_ready | output | 1 | `b_data` holds a valid word |
| almost_empty_n | output | 1 | Low when stored words are at most AE_LEVEL |

## Verification
A table of bursts drives the ordered-delivery path with writes and reads of different lengths. These include single words, a nine-word burst that straddles the almost-empty threshold, and a long burst read to empty. Comparing the flag values with the words left after each burst separates the correct count from an off-by-one. Directed runs cover the following:
- writes and reads with a single qualifier missing, which tell a proper AND of qualifiers from a partial one;
- a run to full with the reader idle, which pins the capacity to exactly DEPTH and places the almost-full edge;
- a mark, rewind and release sequence, which distinguishes a write limit taken from the mark from one taken from the read head.

// File: rtl/mfifo_pkg.sv
package mfifo_pkg;

    // Read-side state: {mark held, output register valid}
    typedef enum logic [1:0] {
        RS_DRY       = 2'b00,
        RS_HOLD      = 2'b01,
        RS_MARK_DRY  = 2'b10,
        RS_MARK_HOLD = 2'b11
    } rd_state_t;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/mfifo_sync.sv
module mfifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/mfifo_ram.sv
module mfifo_ram #(
    parameter int DW = 36,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mfifo_wr.sv
module mfifo_wr
    import mfifo_pkg::*;
#(
    parameter int AW       = 9,
    parameter int DEPTH    = 512,
    parameter int AF_LEVEL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [AW:0]   h_gray_s,
    input  logic [AW:0]   m_gray_s,
    input  logic          marked_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   w_gray,
    output logic [AW:0]   wptr_bin,
    output logic [AW:0]   base_bin,
    output logic          in_ready,
    output logic          almost_full_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr, wptr_nx, fill_nx;

    always_comb begin
        // the oldest word that must survive: the mark while one is held
        base_bin = marked_s ? PW'(gray_to_bin(32'(m_gray_s)))
                            : PW'(gray_to_bin(32'(h_gray_s)));
        we       = wr_req & in_ready;
        wptr_nx  = wptr + PW'(we);
        fill_nx  = wptr_nx - base_bin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr          <= '0;
            w_gray        <= '0;
            in_ready      <= 1'b0;
            almost_full_n <= 1'b1;
        end else begin
            wptr          <= wptr_nx;
            w_gray        <= PW'(bin_to_gray(32'(wptr_nx)));
            in_ready      <= (fill_nx != PW'(DEPTH));
            almost_full_n <= ((PW'(DEPTH) - fill_nx) > PW'(AF_LEVEL));
        end
    end

    assign waddr    = wptr[AW-1:0];
    assign wptr_bin = wptr;
endmodule

// File: rtl/mfifo_rd.sv
module mfifo_rd
    import mfifo_pkg::*;
#(
    parameter int DW       = 36,
    parameter int AW       = 9,
    parameter int AE_LEVEL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          retx_mode,
    input  logic          rewind,
    input  logic [AW:0]   w_gray_s,
    output logic [AW-1:0] raddr,
    input  logic [DW-1:0] rdata,
    output logic [DW-1:0] rd_data,
    output logic          out_ready,
    output logic          almost_empty_n,
    output logic [AW:0]   h_gray,
    output logic [AW:0]   m_gray,
    output logic          marked,
    output logic [AW:0]   mark_bin
);
    localparam int PW = AW + 1;

    rd_state_t     state, state_nx;
    logic          cur_valid, cur_mark;
    logic          rd_go, rew_go, avail, load, nx_valid, nx_mark;
    logic [PW-1:0] rptr, rptr_nx, mark, mark_nx, h_nx, w_bin, cnt_nx;

    // state decode
    always_comb begin
        cur_mark  = 1'b0;
        cur_valid = 1'b0;
        unique case (state)
            RS_DRY:       begin cur_mark = 1'b0; cur_valid = 1'b0; end
            RS_HOLD:      begin cur_mark = 1'b0; cur_valid = 1'b1; end
            RS_MARK_DRY:  begin cur_mark = 1'b1; cur_valid = 1'b0; end
            RS_MARK_HOLD: begin cur_mark = 1'b1; cur_valid = 1'b1; end
        endcase
    end

    // transitions: fetch, drain, mark, release, rewind
    always_comb begin
        w_bin    = PW'(gray_to_bin(32'(w_gray_s)));
        rd_go    = rd_req & cur_valid;
        rew_go   = cur_mark & retx_mode & rewind;
        avail    = (w_bin != rptr);
        load     = !rew_go & (!cur_valid | rd_go) & avail;
        nx_valid = rew_go | load | (cur_valid & !rd_go);
        nx_mark  = retx_mode & (cur_mark | cur_valid);

        case ({nx_mark, nx_valid})
            2'b00:   state_nx = RS_DRY;
            2'b01:   state_nx = RS_HOLD;
            2'b10:   state_nx = RS_MARK_DRY;
            default: state_nx = RS_MARK_HOLD;
        endcase

        raddr   = rew_go ? mark[AW-1:0] : rptr[AW-1:0];
        rptr_nx = rew_go ? mark + PW'(1) : (load ? rptr + PW'(1) : rptr);
        mark_nx = (!cur_mark && nx_mark) ? rptr - PW'(1) : mark;
        h_nx    = rptr_nx - PW'(nx_valid);
        cnt_nx  = w_bin - h_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_DRY;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr           <= '0;
            mark           <= '0;
            rd_data        <= '0;
            h_gray         <= '0;
            m_gray         <= '0;
            almost_empty_n <= 1'b0;
        end else begin
            rptr           <= rptr_nx;
            mark           <= mark_nx;
            if (rew_go || load) begin
                rd_data <= rdata;
            end
            h_gray         <= PW'(bin_to_gray(32'(h_nx)));
            m_gray         <= PW'(bin_to_gray(32'(mark_nx)));
            almost_empty_n <= (cnt_nx > PW'(AE_LEVEL));
        end
    end

    assign out_ready = cur_valid;
    assign marked    = cur_mark;
    assign mark_bin  = mark;
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo #(
    parameter int DW       = 36,
    parameter int DEPTH    = 512,
    parameter int AE_LEVEL = 8,
    parameter int AF_LEVEL = 8
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          rst_n,
    input  logic          a_cs_n,
    input  logic          a_en,
    input  logic          a_wr,
    input  logic [DW-1:0] a_data,
    input  logic          b_cs_n,
    input  logic          b_en,
    input  logic          b_rd,
    input  logic          retx_mode,
    input  logic          rewind,
    output logic [DW-1:0] b_data,
    output logic          in_ready,
    output logic          almost_full_n,
    output logic          out_ready,
    output logic          almost_empty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int XW = 2 * PW + 1;

    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] rdata;
    logic [PW-1:0] w_gray, w_gray_s, h_gray, m_gray, h_gray_s, m_gray_s;
    logic [PW-1:0] wptr_bin, base_bin, mark_bin;
    logic          marked, marked_s;
    logic [XW-1:0] r2w_s;

    mfifo_wr #(.AW(AW), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL)) u_wr (
        .clk(clk_a), .rst_n(rst_n),
        .wr_req(!a_cs_n && a_en && a_wr),
        .h_gray_s(h_gray_s), .m_gray_s(m_gray_s), .marked_s(marked_s),
        .we(we), .waddr(waddr), .w_gray(w_gray),
        .wptr_bin(wptr_bin), .base_bin(base_bin),
        .in_ready(in_ready), .almost_full_n(almost_full_n)
    );

    mfifo_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk(clk_a), .we(we), .waddr(waddr), .wdata(a_data),
        .raddr(raddr), .rdata(rdata)
    );

    mfifo_sync #(.W(PW)) u_w2r (
        .clk(clk_b), .rst_n(rst_n), .d(w_gray), .q(w_gray_s)
    );

    mfifo_sync #(.W(XW)) u_r2w (
        .clk(clk_a), .rst_n(rst_n), .d({marked, m_gray, h_gray}), .q(r2w_s)
    );

    assign h_gray_s = r2w_s[PW-1:0];
    assign m_gray_s = r2w_s[2*PW-1:PW];
    assign marked_s = r2w_s[XW-1];

    mfifo_rd #(.DW(DW), .AW(AW), .AE_LEVEL(AE_LEVEL)) u_rd (
        .clk(clk_b), .rst_n(rst_n),
        .rd_req(!b_cs_n && b_en && b_rd),
        .retx_mode(retx_mode), .rewind(rewind),
        .w_gray_s(w_gray_s), .raddr(raddr), .rdata(rdata),
        .rd_data(b_data), .out_ready(out_ready), .almost_empty_n(almost_empty_n),
        .h_gray(h_gray), .m_gray(m_gray), .marked(marked), .mark_bin(mark_bin)
    );
endmodule

// File: rtl/mark_fifo_chk.sv
module mark_fifo_chk #(
    parameter int PW    = 10,
    parameter int DEPTH = 512
) (
    input logic          clk_a,
    input logic          clk_b,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_ready,
    input logic          almost_full_n,
    input logic          almost_empty_n,
    input logic [PW-1:0] wptr_bin,
    input logic [PW-1:0] base_bin,
    input logic          marked,
    input logic [PW-1:0] mark_bin
);
    // R1: both ready flags held low through reset
    always @(posedge clk_a) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!in_ready && !out_ready)
                else $error("ready flag high during reset");
        end
    end

    // R5: a blocked write leaves the write pointer alone
    p_blocked_write_r5: assert property (@(posedge clk_a) disable iff (!rst_n)
        !in_ready |=> $stable(wptr_bin));

    // R11: occupancy measured from the protected base never exceeds DEPTH
    p_fill_bound_r11: assert property (@(posedge clk_a) disable iff (!rst_n)
        (wptr_bin - base_bin) <= PW'(DEPTH));

    // R8: reaching full also reports almost full
    p_full_flags_r8: assert property (@(posedge clk_a) disable iff (!rst_n)
        $fell(in_ready) |-> !almost_full_n);

    // R7: running dry also reports almost empty
    p_dry_flags_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
        $fell(out_ready) |-> !almost_empty_n);

    // R9: a mark is only taken while a word is shown
    p_mark_entry_r9: assert property (@(posedge clk_b) disable iff (!rst_n)
        $rose(marked) |-> $past(out_ready));

    // R12: the mark point does not move while the mode is held
    p_mark_fixed_r12: assert property (@(posedge clk_b) disable iff (!rst_n)
        (marked && $past(marked)) |-> $stable(mark_bin));
endmodule

bind mark_fifo mark_fifo_chk #(.PW(PW), .DEPTH(DEPTH)) u_mark_fifo_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .in_ready(in_ready), .out_ready(out_ready),
    .almost_full_n(almost_full_n), .almost_empty_n(almost_empty_n),
    .wptr_bin(wptr_bin), .base_bin(base_bin),
    .marked(marked), .mark_bin(mark_bin)
);

// File: tb/mark_fifo_bench.sv
module mark_fifo_bench;
    localparam int DEPTH = 512;

    typedef struct packed {
        int wr_n;
        int rd_n;
        bit exp_or;
        bit exp_ae_n;
    } vec_t;

    // bursts; expected flags from the words left (AE_LEVEL = 8)
    localparam vec_t VEC [7] = '{
        '{1,  0,  1'b1, 1'b0},
        '{0,  1,  1'b0, 1'b0},
        '{9,  0,  1'b1, 1'b1},
        '{0,  1,  1'b1, 1'b0},
        '{20, 28, 1'b0, 1'b0},
        '{3,  1,  1'b1, 1'b0},
        '{0,  2,  1'b0, 1'b0}
    };

    logic        clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic        a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0;
    logic [35:0] a_data = '0;
    logic        b_cs_n = 1'b1, b_en = 1'b0, b_rd = 1'b0;
    logic        retx_mode = 1'b0, rewind = 1'b0;
    logic [35:0] b_data;
    logic        in_ready, almost_full_n, out_ready, almost_empty_n;

    int          n_chk = 0, n_bad = 0, seq = 0;
    bit          done = 0;
    logic [35:0] q [$];

    always #2 begin
        clk_a = ~clk_a;
        clk_b = ~clk_b;
    end

    mark_fifo u_mark_fifo (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_data(a_data),
        .b_cs_n(b_cs_n), .b_en(b_en), .b_rd(b_rd),
        .retx_mode(retx_mode), .rewind(rewind),
        .b_data(b_data), .in_ready(in_ready), .almost_full_n(almost_full_n),
        .out_ready(out_ready), .almost_empty_n(almost_empty_n)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk_a);
    endtask

    function automatic logic [35:0] pat(input int n);
        return {4'h9, n[15:0], ~n[15:0]};
    endfunction

    // one write attempt; stored in the model only if in_ready was high
    task automatic push_word(input logic [35:0] d, output bit took);
        took   = in_ready;
        a_cs_n = 1'b0; a_en = 1'b1; a_wr = 1'b1; a_data = d;
        tick();
        a_en = 1'b0;
        if (took) q.push_back(d);
    endtask

    task automatic push_n(input int n);
        bit t;
        for (int i = 0; i < n; i++) begin
            push_word(pat(seq), t);
            seq++;
        end
    endtask

    task automatic pop_word(input string tag);
        chk({tag, " out_ready"}, 64'(out_ready), 64'd1);
        chk({tag, " data"}, 64'(b_data), 64'(q[0]));
        void'(q.pop_front());
        b_cs_n = 1'b0; b_en = 1'b1; b_rd = 1'b1;
        tick();
        b_en = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        bit          t;
        int          acc;
        logic [35:0] wv [6];

        // R1: reset state
        tick(5);
        chk("R1 in_ready in reset", 64'(in_ready), 64'd0);
        chk("R1 out_ready in reset", 64'(out_ready), 64'd0);
        chk("R1 almost_empty_n in reset", 64'(almost_empty_n), 64'd0);
        chk("R1 almost_full_n in reset", 64'(almost_full_n), 64'd1);
        rst_n = 1'b1;
        tick();
        chk("R1 in_ready after release", 64'(in_ready), 64'd1);

        // R3 R7: burst table
        foreach (VEC[i]) begin
            push_n(VEC[i].wr_n);
            tick(6);
            for (int k = 0; k < VEC[i].rd_n; k++) pop_word("R3 table");
            tick(6);
            chk("R3 table out_ready", 64'(out_ready), 64'(VEC[i].exp_or));
            chk("R7 table almost_empty_n", 64'(almost_empty_n), 64'(VEC[i].exp_ae_n));
        end

        // R4: three-edge output-ready latency
        a_cs_n = 1'b0; a_en = 1'b1; a_wr = 1'b1; a_data = pat(seq);
        q.push_back(pat(seq)); seq++;
        tick();
        a_en = 1'b0;
        chk("R4 edge1", 64'(out_ready), 64'd0);
        tick();
        chk("R4 edge2", 64'(out_ready), 64'd0);
        tick();
        chk("R4 edge3 pending", 64'(out_ready), 64'd0);
        tick();
        chk("R4 third edge", 64'(out_ready), 64'd1);
        pop_word("R4 data");
        tick(6);

        // R6: read while empty is ignored
        b_cs_n = 1'b0; b_en = 1'b1; b_rd = 1'b1;
        tick(4);
        b_en = 1'b0;
        push_n(1);
        tick(6);
        pop_word("R6 late word");

        // R2: write qualifiers
        a_data = pat(999);
        a_cs_n = 1'b1; a_en = 1'b1; a_wr = 1'b1; tick();
        a_cs_n = 1'b0; a_en = 1'b0; a_wr = 1'b1; tick();
        a_cs_n = 1'b0; a_en = 1'b1; a_wr = 1'b0; tick();
        a_en = 1'b0;
        tick(6);
        chk("R2 partial qualifiers store nothing", 64'(out_ready), 64'd0);

        // R3: read qualifiers
        push_n(2);
        tick(6);
        b_cs_n = 1'b1; b_en = 1'b1; b_rd = 1'b1; tick();
        b_cs_n = 1'b0; b_en = 1'b0; b_rd = 1'b1; tick();
        b_cs_n = 1'b0; b_en = 1'b1; b_rd = 1'b0; tick();
        b_en = 1'b0;
        chk("R3 partial read keeps head", 64'(b_data), 64'(q[0]));
        pop_word("R3 qual");
        pop_word("R3 qual");
        tick(6);

        // R5 R8: fill with reader idle
        acc = 0;
        for (int i = 0; i < 520; i++) begin
            push_word(pat(seq), t);
            seq++;
            if (t) begin
                acc++;
                if (acc == 503) chk("R8 free 9", 64'(almost_full_n), 64'd1);
                if (acc == 504) chk("R8 free 8", 64'(almost_full_n), 64'd0);
            end
        end
        chk("R5 capacity", 64'(acc), 64'(DEPTH));
        chk("R5 in_ready at full", 64'(in_ready), 64'd0);
        for (int i = 0; i < DEPTH; i++) pop_word("R5 drain");
        tick(6);
        chk("R5 nothing extra stored", 64'(out_ready), 64'd0);

        // R9 R10: mark and rewind
        for (int i = 0; i < 6; i++) begin
            wv[i] = pat(seq); seq++;
            push_word(wv[i], t);
        end
        tick(6);
        pop_word("R9 pre");
        retx_mode = 1'b1;
        tick();
        chk("R9 marked word shown", 64'(b_data), 64'(wv[1]));
        pop_word("R9 w1");
        pop_word("R9 w2");
        pop_word("R9 w3");
        rewind = 1'b1;
        tick();
        rewind = 1'b0;
        chk("R10 rewind ready", 64'(out_ready), 64'd1);
        chk("R10 rewind data", 64'(b_data), 64'(wv[1]));
        q.delete();
        for (int i = 1; i < 6; i++) q.push_back(wv[i]);
        for (int i = 0; i < 5; i++) pop_word("R10 replay");
        tick(6);
        chk("R10 empty after replay", 64'(out_ready), 64'd0);

        // R11: write limit set by the mark
        acc = 0;
        for (int i = 0; i < 515; i++) begin
            push_word(pat(seq), t);
            seq++;
            if (t) acc++;
        end
        chk("R11 limit from mark", 64'(acc), 64'(DEPTH - 5));
        chk("R11 in_ready low", 64'(in_ready), 64'd0);

        // R12: release the mark
        retx_mode = 1'b0;
        tick();
        rewind = 1'b1;
        tick();
        rewind = 1'b0;
        chk("R12 rewind ignored", 64'(b_data), 64'(q[0]));
        tick(6);
        chk("R12 in_ready returns", 64'(in_ready), 64'd1);
        acc = 0;
        for (int i = 0; i < 10; i++) begin
            push_word(pat(seq), t);
            seq++;
            if (t) acc++;
        end
        chk("R12 limit from head", 64'(acc), 64'd5);
        while (q.size() > 0) pop_word("R12 drain");
        tick(6);
        chk("R12 empty at end", 64'(out_ready), 64'd0);

        done = 1;
        summary();
    end
endmodule